// File: doc/BRIEF.md
# Translation Fault Capture and Interrupt Unit

This block sits beside an address translator and keeps a record of the errors that the translator reports. The translator signals eight kinds of fault as single-cycle pulses. Each pulse comes with the virtual address of the faulting access, the physical address it resolved to, and the identifier of the requester. Software enables each kind of fault on its own. The block accumulates the enabled faults in a status word and holds a level interrupt high while an enabled fault is pending.

Only the first enabled fault after a clear captures the address and requester details. Every later fault only adds its bit to the status word until software clears. Clearing empties the status word and arms the capture again. The block also holds a software-written physical address, aligned to 128 bytes, that the translator uses as a safe target for accesses that fault. The requester identifier is shown both raw and split into a port number and a group number. The group field is stored in reverse order.

Top module: `fault_capture_unit`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: Register index 0 (control) holds cause enables in bits [7:0]. A fault pulse on `evt_cause[i]` sets status bit i only if enable bit i was set before that clock edge. A disabled cause changes nothing.
- R3: `irq` is high exactly when some status bit is set whose enable bit is currently set. It follows the registered state, one cycle after the edge that changes it.
- R4: The first enabled fault after reset or after a clear loads the capture registers. Index 2 returns the faulting virtual address, index 3 the physical address and index 4 the 16-bit requester ID. Later faults leave them unchanged until the next clear.
- R5: Later enabled faults OR their bits into the status word at index 1 and never remove bits already set.
- R6: Writing control with bit 12 set empties the status word and re-arms capture. Bit 12 always reads back as zero, and the enables are written from the same data.
- R7: The faulting virtual address keeps bits [31:12] only, and bits [11:0] read zero.
- R8: Index 5 returns the port number, taken from requester ID bits [11:8], in bits [3:0]. It returns the group number, which is 6 minus ID bits [15:13] modulo 8, in bits [10:8].
- R9: Index 6 and output `protect_addr` hold the written protect address with bits [6:0] forced to zero.
- R10: A fault in the same cycle as a clear is recorded after the clear. Its bits form the new status word, and it captures fresh details.
- R11: Clearing an enable drops `irq` for that cause but keeps its status bit.
- R12: Writes to indices 1 to 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| evt_cause | input | 8 | Fault pulses, one bit per cause |
| evt_va | input | 32 | Virtual address of the faulting access |
| evt_pa | input | 32 | Physical address of the faulting access |
| evt_rid | input | 16 | Requester ID of the faulting access |
| protect_addr | output | 32 | Aligned safe target address |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check four things. Status bits never vanish without a clear, and new status bits only come from causes that were enabled. Captured details stay frozen while capture is locked. A raised interrupt always has a pending status bit behind it. The bench scenarios show the rest: the exact values captured, the reverse group decode and its wrap to 7, the ordering of a clear and a fault in the same cycle, and a disabled enable hiding a status bit that is still set.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    // Register indices decoded on cfg_addr
    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_STATUS = 3'd1;
    localparam logic [2:0] IDX_VA     = 3'd2;
    localparam logic [2:0] IDX_PA     = 3'd3;
    localparam logic [2:0] IDX_RID    = 3'd4;
    localparam logic [2:0] IDX_RIDDEC = 3'd5;
    localparam logic [2:0] IDX_PROT   = 3'd6;

    // Write-one clear position inside the control word
    localparam int unsigned CLR_BIT = 12;

endpackage

// File: rtl/fcu_cfg_regs.sv
module fcu_cfg_regs
    import fcu_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NCAUSE     = 8,
    parameter int unsigned PROT_ALIGN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCAUSE-1:0] en,
    output logic [DATA_W-1:0] prot,
    output logic              clr
);
    localparam int unsigned PHI_W = DATA_W - PROT_ALIGN;

    typedef struct packed {
        logic [NCAUSE-1:0] en;
        logic [PHI_W-1:0]  prot_hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && widx == IDX_CTRL) begin
            cfg_d.en = wdata[NCAUSE-1:0];
        end
        if (we && widx == IDX_PROT) begin
            cfg_d.prot_hi = wdata[DATA_W-1:PROT_ALIGN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en   = cfg_q.en;
    assign prot = {cfg_q.prot_hi, {PROT_ALIGN{1'b0}}};
    assign clr  = we && (widx == IDX_CTRL) && wdata[CLR_BIT];

    // R2: enables only move on a control write
    a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && widx == IDX_CTRL) |=> $stable(en));

endmodule

// File: rtl/fcu_capture.sv
module fcu_capture #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NCAUSE     = 8,
    parameter int unsigned RID_W      = 16,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCAUSE-1:0]          en,
    input  logic                       clr,
    input  logic [NCAUSE-1:0]          evt,
    input  logic [ADDR_W-1:0]          va,
    input  logic [ADDR_W-1:0]          pa,
    input  logic [RID_W-1:0]           rid,
    output logic [NCAUSE-1:0]          status,
    output logic [ADDR_W-PAGE_SHIFT-1:0] va_hi,
    output logic [ADDR_W-1:0]          pa_cap,
    output logic [RID_W-1:0]           rid_cap,
    output logic                       irq
);
    localparam int unsigned VHI_W = ADDR_W - PAGE_SHIFT;

    typedef struct packed {
        logic [NCAUSE-1:0] status;
        logic [VHI_W-1:0]  va_hi;
        logic [ADDR_W-1:0] pa;
        logic [RID_W-1:0]  rid;
        logic              lock;
    } cap_t;

    cap_t st_d, st_q;
    logic [NCAUSE-1:0] hit;
    logic              unused_va_lo;

    assign unused_va_lo = ^va[PAGE_SHIFT-1:0];

    always_comb begin
        st_d = st_q;
        hit  = evt & en;
        if (clr) begin
            st_d.status = '0;
            st_d.lock   = 1'b0;
        end
        st_d.status = st_d.status | hit;
        if (hit != '0 && !st_d.lock) begin
            st_d.va_hi = va[ADDR_W-1:PAGE_SHIFT];
            st_d.pa    = pa;
            st_d.rid   = rid;
            st_d.lock  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status  = st_q.status;
    assign va_hi   = st_q.va_hi;
    assign pa_cap  = st_q.pa;
    assign rid_cap = st_q.rid;
    assign irq     = |(st_q.status & en);

    // R4: locked details stay frozen until a clear
    a_r4_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !clr) |=> ($stable(va_hi) && $stable(pa_cap) && $stable(rid_cap)));

    // R5: without a clear no status bit is lost
    a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));

    // R2: newly set status bits were enabled
    a_r2_new_bits_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(en)) == '0));

    // R6: after a clear only that cycle's enabled faults remain
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == $past(evt & en)));

    // R3: a raised interrupt has a pending cause behind it
    a_r3_irq_backed: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.lock && status != '0));

endmodule

// File: rtl/fcu_rid_decode.sv
module fcu_rid_decode #(
    parameter int unsigned RID_W    = 16,
    parameter int unsigned PORT_LSB = 8,
    parameter int unsigned PORT_W   = 4,
    parameter int unsigned GRP_LSB  = 13,
    parameter int unsigned GRP_W    = 3,
    parameter int unsigned GRP_BASE = 6
) (
    input  logic [RID_W-1:0]  rid,
    output logic [PORT_W-1:0] port,
    output logic [GRP_W-1:0]  group
);
    localparam logic [GRP_W-1:0] BASE = GRP_W'(GRP_BASE);

    always_comb begin
        port  = rid[PORT_LSB +: PORT_W];
        group = BASE - rid[GRP_LSB +: GRP_W];
    end

endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit
    import fcu_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NCAUSE     = 8,
    parameter int unsigned RID_W      = 16,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned PROT_ALIGN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [NCAUSE-1:0] evt_cause,
    input  logic [DATA_W-1:0] evt_va,
    input  logic [DATA_W-1:0] evt_pa,
    input  logic [RID_W-1:0]  evt_rid,
    output logic [DATA_W-1:0] protect_addr,
    output logic              irq
);
    localparam int unsigned PORT_W = 4;
    localparam int unsigned GRP_W  = 3;
    localparam int unsigned GRP_POS = 8;

    logic [NCAUSE-1:0]            en;
    logic                         clr;
    logic [NCAUSE-1:0]            status;
    logic [DATA_W-PAGE_SHIFT-1:0] va_hi;
    logic [DATA_W-1:0]            pa_cap;
    logic [RID_W-1:0]             rid_cap;
    logic [PORT_W-1:0]            port;
    logic [GRP_W-1:0]             group;

    fcu_cfg_regs #(
        .DATA_W     (DATA_W),
        .NCAUSE     (NCAUSE),
        .PROT_ALIGN (PROT_ALIGN)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cfg_addr),
        .wdata (cfg_wdata),
        .en    (en),
        .prot  (protect_addr),
        .clr   (clr)
    );

    fcu_capture #(
        .ADDR_W     (DATA_W),
        .NCAUSE     (NCAUSE),
        .RID_W      (RID_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .clr     (clr),
        .evt     (evt_cause),
        .va      (evt_va),
        .pa      (evt_pa),
        .rid     (evt_rid),
        .status  (status),
        .va_hi   (va_hi),
        .pa_cap  (pa_cap),
        .rid_cap (rid_cap),
        .irq     (irq)
    );

    fcu_rid_decode #(
        .RID_W  (RID_W),
        .PORT_W (PORT_W),
        .GRP_W  (GRP_W)
    ) u_dec (
        .rid   (rid_cap),
        .port  (port),
        .group (group)
    );

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            IDX_CTRL:   cfg_rdata[NCAUSE-1:0] = en;
            IDX_STATUS: cfg_rdata[NCAUSE-1:0] = status;
            IDX_VA:     cfg_rdata[DATA_W-1:PAGE_SHIFT] = va_hi;
            IDX_PA:     cfg_rdata = pa_cap;
            IDX_RID:    cfg_rdata[RID_W-1:0] = rid_cap;
            IDX_RIDDEC: begin
                cfg_rdata[PORT_W-1:0]          = port;
                cfg_rdata[GRP_POS +: GRP_W]    = group;
            end
            IDX_PROT:   cfg_rdata = protect_addr;
            default:    cfg_rdata = '0;
        endcase
    end

    // R9: the protect target keeps its alignment on the port
    a_r9_protect_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        protect_addr[PROT_ALIGN-1:0] == '0);

endmodule

// File: tb/fault_capture_unit_test.sv
module fault_capture_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  evt_cause = '0;
    logic [31:0] evt_va = '0;
    logic [31:0] evt_pa = '0;
    logic [15:0] evt_rid = '0;
    logic [31:0] protect_addr;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    fault_capture_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_cause(evt_cause),
        .evt_va(evt_va), .evt_pa(evt_pa), .evt_rid(evt_rid),
        .protect_addr(protect_addr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [7:0]  m_en, m_status;
    logic [31:0] m_va, m_pa, m_prot;
    logic [15:0] m_rid;
    bit          m_lock;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_status = 0; m_va = 0; m_pa = 0; m_prot = 0; m_rid = 0; m_lock = 0;
        end else begin
            bit clear;
            logic [7:0] fired;
            clear = cfg_we && cfg_addr == 3'd0 && cfg_wdata[12];
            fired = evt_cause & m_en;
            if (clear) begin
                m_status = 0;
                m_lock = 0;
            end
            m_status = m_status | fired;
            if (fired != 0 && !m_lock) begin
                m_va = {evt_va[31:12], 12'h000};
                m_pa = evt_pa;
                m_rid = evt_rid;
                m_lock = 1;
            end
            if (cfg_we && cfg_addr == 3'd0) m_en = cfg_wdata[7:0];
            if (cfg_we && cfg_addr == 3'd6) m_prot = cfg_wdata & 32'hFFFF_FF80;
        end
    end

    function automatic logic [31:0] expect_read(input int idx);
        int grp;
        case (idx)
            0: return {24'h0, m_en};
            1: return {24'h0, m_status};
            2: return m_va;
            3: return m_pa;
            4: return {16'h0, m_rid};
            5: begin
                grp = (6 - int'(m_rid[15:13])) & 7;
                return {21'h0, 3'(grp), 4'h0, m_rid[11:8]};
            end
            6: return m_prot;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the registered outputs (R3, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 irq level", {31'h0, irq}, {31'h0, |(m_status & m_en)});
            check("R9 protect port", protect_addr, m_prot);
        end
    end

    task automatic rd(input int idx, input string tag);
        @(negedge clk);
        cfg_addr = 3'(idx);
        #1;
        check(tag, cfg_rdata, expect_read(idx));
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 7; i++) rd(i, tag);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic ev(input logic [7:0] c, input logic [31:0] va, input logic [31:0] pa,
                      input logic [15:0] rid, input bit with_clear);
        @(negedge clk);
        evt_cause = c; evt_va = va; evt_pa = pa; evt_rid = rid;
        if (with_clear) begin
            cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = {19'h0, 1'b1, 4'h0, m_en};
        end
        @(negedge clk);
        evt_cause = 0; cfg_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd_all("R1 reset value");
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        wr(0, 32'h0000_0005);
        rd(0, "R2 enable readback");
        ev(8'h02, 32'hDEAD_B123, 32'h1111_0000, 16'h1234, 0);
        rd(1, "R2 disabled cause ignored");
        rd(2, "R2 no capture on disabled cause");
        check("R2 irq stays low", {31'h0, irq}, 32'h0);

        ev(8'h01, 32'h1234_5ABC, 32'h8000_4000, 16'hA300, 0);
        rd_all("R4 first capture");
        rd(2, "R7 va low bits zero");
        rd(5, "R8 rid decode");
        ev(8'h04, 32'hFFFF_FFFF, 32'h2222_2222, 16'hFFFF, 0);
        rd(1, "R5 status or");
        rd(2, "R4 va held");
        rd(3, "R4 pa held");
        rd(4, "R4 rid held");

        wr(1, 32'hFF); wr(2, 32'hFFFF_FFFF); wr(3, 0); wr(4, 0); wr(5, 32'h7FF);
        rd_all("R12 read-only regs unchanged");

        wr(0, 32'h0000_0001);
        check("R11 irq kept by bit0", {31'h0, irq}, 32'h1);
        wr(0, 32'h0000_0000);
        check("R11 irq low with enables off", {31'h0, irq}, 32'h0);
        rd(1, "R11 status kept");

        wr(0, 32'h0000_10FF);
        rd(0, "R6 clear bit reads zero");
        rd(1, "R6 status emptied");
        ev(8'h30, 32'hCAFE_0FFF, 32'h0000_1000, 16'hE500, 0);
        rd_all("R6 re-armed capture");
        rd(5, "R8 group wraps");

        ev(8'h08, 32'h0BAD_F00D, 32'h3333_3333, 16'h0F00, 1);
        rd_all("R10 clear with fault");
        rd(5, "R8 group top");

        wr(6, 32'hFFFF_FFFF);
        rd(6, "R9 protect aligned");
        wr(6, 32'h1234_56C7);
        rd(6, "R9 protect aligned 2");
        ev(8'h80, 32'h0, 32'h0, 16'h0, 0);
        rd(1, "R5 high cause");

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        vectors++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule